// File: doc/BRIEF.md
# Minicomputer Shift and Rotate Unit

This unit executes the shift group of a 16-bit-word minicomputer. Each accepted operation carries a 10-bit shift field from the instruction word, the current accumulator word `A`, the companion word `B`, the carry/link flag, a legacy-mode select and the integer-overflow trap enable. The unit decodes the operation from bits 9:6 and the count from bits 5:0. It then produces the new `A`, `B` and carry one clock later. A 16-bit operation works on `A` alone. A long operation works on the pair `{A,B}` with `A` as the upper half.

In legacy mode, the long arithmetic shifts treat the pair as a 31-bit quantity built from `A` and `B[14:0]`, and `B[15]` is carried through untouched. Arithmetic left shifts can raise an overflow trap request. Opcodes outside the shift table are reported as illegal, and the registers are not modified.

Top module: `shift_rotate_unit`

## Requirements
- R1: The count is n = (64 - field[5:0]) mod 64, and n = 0 stands for 64. So field 0x3F means one place and field 0x00 means 64 places.
- R2: Opcode field[9:6] is decoded as follows. 0/1/2 are long logical right, arithmetic right and rotate right. 4/5/6 are the same three on `A` alone. 8/9/10 are long logical left, arithmetic left and rotate left. 12/13/14 are the same three on `A` alone. A 16-bit operation returns `B` unchanged.
- R3: A logical shift by n ≤ width fills with zeros, and the carry takes the last bit shifted out. For n > width, the result is 0 and the carry is 0.
- R4: A rotate uses k = ((n-1) mod width)+1 places, and the carry takes the last bit carried around. A 16-bit rotate by 16 or 32 places returns `A` unchanged.
- R5: An arithmetic right shift replicates the sign bit, and the carry takes the last bit shifted out. When n exceeds the width, every result bit and the carry all equal the sign.
- R6: An arithmetic left shift by n < width shifts in zeros. The carry is set when the top n+1 bits of the operand are not all equal. For n ≥ width, the result is 0 and the carry is set when the operand was nonzero.
- R7: With legacy mode high, opcodes 1 and 9 operate on the 31-bit value {A, B[14:0]}. The result is written back as A = bits 30:15 and B[14:0] = bits 14:0, and B[15] keeps its input value. The width used in R5 and R6 is then 31.
- R8: With legacy mode high, opcode 1 with n ≥ 32 gives all ones if A[15] was 1 and all zeros otherwise, and the carry equals A[15].
- R9: For opcodes 9 and 13, the overflow trap request equals the new carry ANDed with the trap enable. For every other opcode, the trap request is 0.
- R10: Opcodes 3, 7, 11 and 15 raise the illegal-operation output. `A`, `B` and the carry are then returned unchanged, and there is no trap request.
- R11: `in_ready` is always high. Each clock with `in_valid` high produces `out_valid` high on the next clock, with the results. A clock without `in_valid` drops `out_valid` and holds the result outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation presented this clock |
| in_ready | output | 1 | Unit can accept (always 1) |
| op_word | input | 10 | Opcode in bits 9:6, negated count in bits 5:0 |
| a_in | input | 16 | Accumulator operand |
| b_in | input | 16 | Low word of the pair |
| carry_in | input | 1 | Current carry/link |
| legacy_mode | input | 1 | Selects the 31-bit form for opcodes 1 and 9 |
| ovf_trap_en | input | 1 | Integer-overflow trap enable |
| out_valid | output | 1 | Results below are new this clock |
| a_out | output | 16 | Resulting accumulator |
| b_out | output | 16 | Resulting low word |
| carry_out | output | 1 | Resulting carry/link |
| ovf_trap | output | 1 | Overflow trap request |
| illegal_op | output | 1 | Opcode not in the shift table |

## Verification
Every result is registered once. A wrong count decode, a wrong fold of the rotate count or a wrong carry selection therefore appears on `a_out`, `b_out` or `carry_out` exactly one clock after the operation is accepted. The bench compares every output on every clock against a bit-serial model. That model steps the operand one place at a time, so an off-by-one in the count or in the carry position is caught on the first vector that exercises it. An error in the hold path shows up on the first idle clock, as outputs that change while `out_valid` is low.

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [9:0]  op_word,
  input  logic [15:0] a_in,
  input  logic [15:0] b_in,
  input  logic        carry_in,
  input  logic        legacy_mode,
  input  logic        ovf_trap_en,
  output logic        out_valid,
  output logic [15:0] a_out,
  output logic [15:0] b_out,
  output logic        carry_out,
  output logic        ovf_trap,
  output logic        illegal_op
);

  wire [3:0]  op   = op_word[9:6];
  wire [5:0]  neg6 = 6'd0 - op_word[5:0];
  wire [6:0]  n    = (neg6 == 6'd0) ? 7'd64 : {1'b0, neg6};
  wire [4:0]  nm1  = 5'(n - 7'd1);
  wire [4:0]  k16  = {1'b0, nm1[3:0]} + 5'd1;
  wire [5:0]  k32  = {1'b0, nm1[4:0]} + 6'd1;
  wire [31:0] pair = {a_in, b_in};
  wire [30:0] t31  = {a_in, b_in[14:0]};

  wire [32:0] lr32 = {pair, 1'b0} >> n;
  wire [32:0] ll32 = {1'b0, pair} << n;
  wire [16:0] lr16 = {a_in, 1'b0} >> n;
  wire [16:0] ll16 = {1'b0, a_in} << n;

  wire [32:0] ar32 = 33'({{64{pair[31]}}, pair, 1'b0} >> n);
  wire [16:0] ar16 = 17'({{64{a_in[15]}}, a_in, 1'b0} >> n);
  wire [31:0] ar31 = 32'({{64{a_in[15]}}, t31, 1'b0} >> n);

  wire [31:0] rr32 = 32'({pair, pair} >> k32);
  wire [31:0] rl32 = 32'({pair, pair} >> (6'd32 - k32));
  wire [15:0] rr16 = 16'({a_in, a_in} >> k16);
  wire [15:0] rl16 = 16'({a_in, a_in} >> (5'd16 - k16));

  wire [15:0] m16 = ~(16'hFFFF >> (n + 7'd1));
  wire [31:0] m32 = ~(32'hFFFF_FFFF >> (n + 7'd1));
  wire [30:0] m31 = ~(31'h7FFF_FFFF >> (n + 7'd1));
  wire [15:0] al16 = a_in << n;
  wire [31:0] al32 = pair << n;
  wire [30:0] al31 = t31 << n;
  wire c_al16 = (n <= 7'd15) ? (((a_in & m16) != 16'd0) && ((a_in & m16) != m16)) : (a_in != 16'd0);
  wire c_al32 = (n <= 7'd31) ? (((pair & m32) != 32'd0) && ((pair & m32) != m32)) : (pair != 32'd0);
  wire c_al31 = (n <= 7'd30) ? (((t31 & m31) != 31'd0) && ((t31 & m31) != m31)) : (t31 != 31'd0);

  logic [15:0] na, nb;
  logic        nc, novf, nill;

  always_comb begin
    na   = a_in;
    nb   = b_in;
    nc   = carry_in;
    novf = 1'b0;
    nill = 1'b0;
    case (op)
      4'd0:  begin {na, nb} = lr32[32:1]; nc = lr32[0]; end
      4'd1:  if (legacy_mode) begin
               na = ar31[31:16]; nb = {b_in[15], ar31[15:1]}; nc = ar31[0];
             end else begin
               {na, nb} = ar32[32:1]; nc = ar32[0];
             end
      4'd2:  begin {na, nb} = rr32; nc = rr32[31]; end
      4'd4:  begin na = lr16[16:1]; nc = lr16[0]; end
      4'd5:  begin na = ar16[16:1]; nc = ar16[0]; end
      4'd6:  begin na = rr16; nc = rr16[15]; end
      4'd8:  begin {na, nb} = ll32[31:0]; nc = ll32[32]; end
      4'd9:  begin
               if (legacy_mode) begin
                 na = al31[30:15]; nb = {b_in[15], al31[14:0]}; nc = c_al31;
               end else begin
                 {na, nb} = al32; nc = c_al32;
               end
               novf = nc & ovf_trap_en;
             end
      4'd10: begin {na, nb} = rl32; nc = rl32[0]; end
      4'd12: begin na = ll16[15:0]; nc = ll16[16]; end
      4'd13: begin na = al16; nc = c_al16; novf = nc & ovf_trap_en; end
      4'd14: begin na = rl16; nc = rl16[0]; end
      default: nill = 1'b1;
    endcase
  end

  assign in_ready = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      a_out      <= 16'd0;
      b_out      <= 16'd0;
      carry_out  <= 1'b0;
      ovf_trap   <= 1'b0;
      illegal_op <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        a_out      <= na;
        b_out      <= nb;
        carry_out  <= nc;
        ovf_trap   <= novf;
        illegal_op <= nill;
      end
    end
  end

endmodule

// File: rtl/shift_rotate_unit_chk.sv
module shift_rotate_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [9:0]  op_word,
  input logic [15:0] a_in,
  input logic [15:0] b_in,
  input logic        carry_in,
  input logic        legacy_mode,
  input logic        ovf_trap_en,
  input logic        out_valid,
  input logic [15:0] a_out,
  input logic [15:0] b_out,
  input logic        carry_out,
  input logic        ovf_trap,
  input logic        illegal_op
);

  wire [3:0] op      = op_word[9:6];
  wire       is_ill  = (op[1:0] == 2'b11);
  wire       is_16   = op[2] && !is_ill;
  wire       is_asl  = (op == 4'd9) || (op == 4'd13);

  assert_in_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);

  assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(a_out) && $stable(b_out) && $stable(carry_out)));

  assert_b_untouched_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_16) |=> (b_out == $past(b_in)));

  assert_wide_logical_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd4 && op_word[5:0] == 6'd0) |=> (a_out == 16'd0 && !carry_out));

  assert_full_rotate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd6 && op_word[5:0] == 6'd48) |=> (a_out == $past(a_in)));

  assert_legacy_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && legacy_mode && (op == 4'd1 || op == 4'd9)) |=> (b_out[15] == $past(b_in[15])));

  assert_legacy_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && legacy_mode && op == 4'd1 && op_word[5:0] == 6'd0)
    |=> (carry_out == $past(a_in[15]) && a_out == {16{$past(a_in[15])}}));

  assert_trap_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_trap |-> (carry_out && !illegal_op));

  assert_trap_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (!is_asl || !ovf_trap_en)) |=> !ovf_trap);

  assert_illegal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_ill) |=> (illegal_op && a_out == $past(a_in) && b_out == $past(b_in)
                              && carry_out == $past(carry_in)));

endmodule

bind shift_rotate_unit shift_rotate_unit_chk u_chk (.*);

// File: tb/shift_rotate_unit_bench.sv
module shift_rotate_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [9:0]  op_word = '0;
  logic [15:0] a_in = '0, b_in = '0;
  logic        carry_in = 1'b0, legacy_mode = 1'b0, ovf_trap_en = 1'b0;
  logic        out_valid;
  logic [15:0] a_out, b_out;
  logic        carry_out, ovf_trap, illegal_op;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  logic [15:0] ea = '0, eb = '0;
  logic        ec = 0, eovf = 0, eill = 0, evld = 0;
  string       etag = "R11";

  always #2 clk = ~clk;

  shift_rotate_unit u_shift_rotate_unit (.*);

  function automatic void model(input logic [9:0] w, input logic [15:0] a, input logic [15:0] b,
                                input logic c, input logic leg, input logic en,
                                output logic [15:0] ra, output logic [15:0] rb,
                                output logic rc, output logic rovf, output logic rill);
    int op, n, wd, k;
    bit is16, lg31, sgn, nz;
    longint unsigned v, msk;
    op = int'(w[9:6]);
    n = (64 - int'(w[5:0])) % 64;
    if (n == 0) n = 64;
    ra = a; rb = b; rc = c; rovf = 0; rill = 0;
    if ((op % 4) == 3) begin rill = 1; return; end
    is16 = (op & 4) != 0;
    lg31 = leg && (op == 1 || op == 9);
    wd = is16 ? 16 : (lg31 ? 31 : 32);
    v = is16 ? longint'(a) : (lg31 ? longint'({a, b[14:0]}) : longint'({a, b}));
    msk = (64'd1 << wd) - 1;
    sgn = v[wd-1];
    if (op >= 8) begin
      if (op % 4 == 0) begin
        for (int i = 0; i < n; i++) begin rc = v[wd-1]; v = (v << 1) & msk; end
      end else if (op % 4 == 1) begin
        if (n < wd) begin
          rc = 0;
          for (int i = 0; i < n; i++) begin
            if (v[wd-1] != v[wd-2]) rc = 1;
            v = (v << 1) & msk;
          end
        end else begin
          nz = (v != 0); v = 0; rc = nz;
        end
        rovf = rc & en;
      end else begin
        k = ((n - 1) % wd) + 1;
        for (int i = 0; i < k; i++) begin rc = v[wd-1]; v = ((v << 1) & msk) | longint'(rc); end
      end
    end else begin
      if (op % 4 == 0) begin
        for (int i = 0; i < n; i++) begin rc = v[0]; v = v >> 1; end
      end else if (op % 4 == 1) begin
        for (int i = 0; i < n; i++) begin rc = v[0]; v = (v >> 1) | (longint'(sgn) << (wd - 1)); end
      end else begin
        k = ((n - 1) % wd) + 1;
        for (int i = 0; i < k; i++) begin rc = v[0]; v = (v >> 1) | (longint'(rc) << (wd - 1)); end
      end
    end
    if (is16) ra = v[15:0];
    else if (lg31) begin ra = v[30:15]; rb = {b[15], v[14:0]}; end
    else begin ra = v[31:16]; rb = v[15:0]; end
  endfunction

  function automatic string tag_of(input logic [9:0] w, input logic leg);
    int op;
    string s;
    op = int'(w[9:6]);
    case (op)
      0, 4, 8, 12: s = "R3";
      1:           s = leg ? "R7 R8" : "R5";
      5:           s = "R5";
      2, 6, 10, 14: s = "R4";
      9:           s = leg ? "R7 R6" : "R6";
      13:          s = "R6";
      default:     s = "R10";
    endcase
    if (w[5:0] == 6'd0 || w[5:0] == 6'h3F) s = {s, " R1"};
    return s;
  endfunction

  task automatic chk1(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk1("R11", "out_valid", 16'(out_valid), 16'(evld));
    chk1(etag, "a_out", a_out, ea);
    chk1(etag, "b_out", b_out, eb);
    chk1(etag, "carry_out", 16'(carry_out), 16'(ec));
    chk1("R9", "ovf_trap", 16'(ovf_trap), 16'(eovf));
    chk1("R10", "illegal_op", 16'(illegal_op), 16'(eill));
    chk1("R11", "in_ready", 16'(in_ready), 16'd1);
  endtask

  task automatic step(input logic v, input logic [9:0] w, input logic [15:0] a, input logic [15:0] b,
                      input logic c, input logic leg, input logic en);
    logic [15:0] ra, rb;
    logic rc, ro, ri;
    @(negedge clk);
    compare();
    in_valid = v; op_word = w; a_in = a; b_in = b;
    carry_in = c; legacy_mode = leg; ovf_trap_en = en;
    evld = v;
    if (v) begin
      model(w, a, b, c, leg, en, ra, rb, rc, ro, ri);
      ea = ra; eb = rb; ec = rc; eovf = ro; eill = ri;
      etag = tag_of(w, leg);
      if (w[9:6] >= 4'd4 && w[9:6] <= 4'd6) etag = {etag, " R2"};
    end else begin
      etag = "R11";
    end
  endtask

  function automatic logic [9:0] mk(input int op, input int n);
    return {4'(op), 6'((64 - n) % 64)};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk1("R11", "reset out_valid", 16'(out_valid), 16'd0);
    chk1("R11", "reset a_out", a_out, 16'd0);
    chk1("R10", "reset illegal_op", 16'(illegal_op), 16'd0);
    rst_n = 1'b1;
    // R1: count 1 and count 64
    step(1, mk(4, 1),  16'h8001, 16'h1234, 0, 0, 0);
    step(1, mk(4, 64), 16'hFFFF, 16'h1234, 1, 0, 0);
    step(1, mk(12, 16), 16'h0001, 16'h0000, 0, 0, 0);
    step(1, mk(12, 17), 16'hFFFF, 16'h0000, 1, 0, 0);   // R3 beyond width
    step(1, mk(0, 32), 32'h0, 16'h0001, 0, 0, 0);
    step(1, mk(8, 33), 16'h8000, 16'h0000, 1, 0, 0);
    step(1, mk(6, 16), 16'hA5C3, 16'h0000, 0, 0, 0);    // R4 full rotate
    step(1, mk(6, 33), 16'h0003, 16'h0000, 0, 0, 0);
    step(1, mk(14, 64), 16'h8001, 16'h0000, 0, 0, 0);
    step(1, mk(2, 1), 16'h0000, 16'h0001, 0, 0, 0);
    step(1, mk(10, 40), 16'h8000, 16'h0001, 0, 0, 0);
    step(1, mk(5, 20), 16'h8000, 16'h0000, 0, 0, 0);    // R5 sign fill
    step(1, mk(1, 40), 16'h4000, 16'hFFFF, 1, 0, 0);
    step(1, mk(1, 33), 16'h8000, 16'h0000, 0, 0, 0);
    step(1, mk(13, 1), 16'h4000, 16'h0000, 0, 0, 1);    // R6 R9 overflow
    step(1, mk(13, 1), 16'h4000, 16'h0000, 0, 0, 0);
    step(1, mk(13, 3), 16'hF000, 16'h0000, 1, 0, 1);
    step(1, mk(13, 16), 16'h0001, 16'h0000, 0, 0, 1);
    step(1, mk(9, 31), 16'hFFFF, 16'hFFFF, 0, 0, 1);
    step(1, mk(9, 2), 16'h2000, 16'h0000, 0, 1, 1);     // R7 legacy left
    step(1, mk(9, 4), 16'h0000, 16'h8001, 0, 1, 0);
    step(1, mk(1, 1), 16'h0000, 16'h8001, 0, 1, 0);     // R7 legacy right
    step(1, mk(1, 16), 16'h8000, 16'h7FFF, 0, 1, 0);
    step(1, mk(1, 32), 16'h8000, 16'h0000, 0, 1, 0);    // R8
    step(1, mk(1, 64), 16'h7FFF, 16'h8000, 1, 1, 0);
    step(1, mk(3, 5), 16'h1111, 16'h2222, 1, 0, 1);     // R10
    step(1, mk(7, 5), 16'h3333, 16'h4444, 0, 0, 0);
    step(1, mk(11, 9), 16'h5555, 16'h6666, 1, 1, 1);
    step(1, mk(15, 1), 16'h7777, 16'h8888, 0, 0, 0);
    step(0, mk(4, 3), 16'hDEAD, 16'hBEEF, 1, 0, 0);     // R11 idle hold
    step(0, mk(8, 3), 16'h0F0F, 16'hF0F0, 0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      logic [9:0] w;
      w = 10'($urandom);
      if ((i % 7) == 0) w[5:0] = 6'd0;
      if ((i % 7) == 1) w[5:0] = 6'h3F;
      step(($urandom % 8) != 0, w, 16'($urandom), 16'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom));
    end
    step(0, '0, '0, '0, 0, 0, 0);
    @(negedge clk);
    compare();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule